// File: doc/BRIEF.md
# Serial Management Interface Master

This block is the management-side master of a two-wire PHY management link, as defined in clause 22 of the Ethernet standard. Software writes a fully encoded 32-bit command word. The block then generates the management clock (MDC) from the system clock and shifts out a 32-bit all-ones preamble followed by the command word, most significant bit first. For a read, the block releases the data line at the turnaround and captures the 16 bits the PHY returns into the low half of the same word. Completion raises a sticky event bit, which software clears by writing a one to it.

Command word layout: bits 31:30 are the start pattern (01). Bits 29:28 are the opcode: 10 is a read, and any other value is treated as a write that drives all 32 bits. Bits 27:23 are the PHY address, bits 22:18 are the register index, bits 17:16 are the turnaround (10), and bits 15:0 are the write data. Typical bases are 0x6002_0000 for a read and 0x5002_0000 for a write.

A speed register sets the number of system clocks in each MDC half period, so MDC runs at the system clock divided by twice that value. The block computes the smallest legal half period from the `CLK_HZ` and `MDC_MAX_HZ` parameters (the maximum defaults to 2.5 MHz) and raises any smaller non-zero setting to that floor. A speed value of zero parks the link.

Controller states:
- `ST_IDLE`: waits for a command write with a non-zero speed.
- `ST_PREAMBLE`: counts 32 MDC periods with MDIO driven high.
- `ST_FRAME`: shifts the 32 command bits and returns to `ST_IDLE` at the falling MDC edge of bit 31.

Each MDC falling edge advances the bit counter.

Write ports, selected by `wr_addr`:
- 0: command/data word.
- 1: speed field.
- 2: event register; writing a 1 in bit 0 clears the event.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, `mdc` is 0, `mdio_oe` is 0, `mii_done` is 0 and `rd_data` is 0. While no frame is running, `mdc` stays 0 and `mdio_oe` stays 0.
- R2: Every frame starts with 32 MDC periods in which `mdio_oe` is 1 and `mdio_o` is 1.
- R3: After the preamble, the 32 command bits appear on `mdio_o` MSB first, one per MDC period. A frame is exactly 64 MDC periods.
- R4: For a read (bits 29:28 = 10), `mdio_oe` is 1 for command bits 31..18 and 0 from bit 17 (the first turnaround bit) through bit 0. For any other opcode, `mdio_oe` is 1 for the whole frame.
- R5: After a read frame, `rd_data[15:0]` holds the 16 values of `mdio_i` sampled at the rising MDC edges of bits 15..0, first sample in bit 15. `rd_data[31:16]` is unchanged.
- R6: A read with nobody driving the line (pulled high) returns 0xFFFF in `rd_data[15:0]`.
- R7: MDC high and low phases each last max(S, H) system clocks, where S is the speed field and H = ceil(CLK_HZ / (2·MDC_MAX_HZ)); H is 10 at defaults.
- R8: With a speed field of 0, a command write updates `rd_data` but starts no frame: `mdc` stays low and `mii_done` stays 0. Setting the speed field non-zero later does not start that frame.
- R9: `mii_done` sets when a frame ends and stays set. Writing 1 to bit 0 of address 2 clears it, and writing 0 there leaves it set.
- R10: A command write during a running frame is ignored. The frame on the wire and `rd_data` keep the original command.
- R11: `mdio_o` and `mdio_oe` change only while MDC is low; they are never updated while MDC is high.
- R12: After a write frame, `rd_data` still equals the command word written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write target: 0 command, 1 speed, 2 event clear |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Command/data word readback |
| mii_done | output | 1 | Sticky frame-complete event |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
The bench sweeps the speed field across the clamp floor (zero, below, at and above H). A divider that ignored the floor would show a short MDC high time, and one that ignored zero would toggle MDC. It sweeps reads over several address, register and data patterns with a PHY model that drives bits after the bench sees the line released. A turnaround release one bit early or late would shift or corrupt every captured word, and capturing on the wrong MDC edge would misalign it by one bit. It also writes a second command mid-frame, where a design without a busy lock would corrupt the word on the wire. Finally it checks the event bit against a write of 0 and a write of 1.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_PREAMBLE = 2'd1,
        ST_FRAME    = 2'd2
    } mdio_state_e;

    localparam int          PRE_BITS   = 32;
    localparam int          FRAME_BITS = 32;
    localparam int          CNT_W      = 5;
    // frame position (0 = command bit 31) of the first turnaround bit
    localparam int          TA_POS     = 14;
    // frame position of read data bit 15
    localparam int          DATA_POS   = 16;
    localparam logic [1:0]  OP_READ    = 2'b10;

    localparam logic [1:0]  ADDR_CMD   = 2'd0;
    localparam logic [1:0]  ADDR_SPEED = 2'd1;
    localparam logic [1:0]  ADDR_EVENT = 2'd2;
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
    parameter int SPD_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SPD_W-1:0] half,
    output logic             mdc,
    output logic             rise_p,
    output logic             fall_p
);
    logic [SPD_W-1:0] cnt_q;
    logic             wrap;

    assign wrap   = run && (cnt_q == half - SPD_W'(1));
    assign rise_p = wrap && !mdc;
    assign fall_p = wrap &&  mdc;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc   <= ~mdc;
        end else begin
            cnt_q <= cnt_q + SPD_W'(1);
        end
    end
endmodule

// File: rtl/mdio_ctrl_fsm.sv
module mdio_ctrl_fsm
    import mdio_mgmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             fall_p,
    output logic             busy,
    output logic             run,
    output logic             load_first,
    output logic             shift_en,
    output logic             finish,
    output logic             in_data,
    output logic [CNT_W-1:0] bit_idx
);
    mdio_state_e      state_q, state_d;
    logic [CNT_W-1:0] bit_q, bit_d;
    logic             last_bit;

    assign last_bit = (bit_q == CNT_W'(FRAME_BITS - 1));
    assign bit_idx  = bit_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
        end else begin
            state_q <= state_d;
            bit_q   <= bit_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        bit_d   = bit_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_PREAMBLE;
                    bit_d   = '0;
                end
            end
            ST_PREAMBLE: begin
                if (fall_p) begin
                    if (bit_q == CNT_W'(PRE_BITS - 1)) begin
                        state_d = ST_FRAME;
                        bit_d   = '0;
                    end else begin
                        bit_d = bit_q + CNT_W'(1);
                    end
                end
            end
            ST_FRAME: begin
                if (fall_p) begin
                    if (last_bit) begin
                        state_d = ST_IDLE;
                        bit_d   = '0;
                    end else begin
                        bit_d = bit_q + CNT_W'(1);
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
                bit_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        busy       = 1'b0;
        run        = 1'b0;
        load_first = 1'b0;
        shift_en   = 1'b0;
        finish     = 1'b0;
        in_data    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_PREAMBLE: begin
                busy       = 1'b1;
                run        = 1'b1;
                load_first = fall_p && (bit_q == CNT_W'(PRE_BITS - 1));
            end
            ST_FRAME: begin
                busy     = 1'b1;
                run      = 1'b1;
                shift_en = fall_p && !last_bit;
                finish   = fall_p && last_bit;
                in_data  = (bit_q >= CNT_W'(DATA_POS));
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/mdio_frame_path.sv
module mdio_frame_path
    import mdio_mgmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [31:0]      wdata,
    input  logic             start,
    input  logic             load_first,
    input  logic             shift_en,
    input  logic             finish,
    input  logic             in_data,
    input  logic [CNT_W-1:0] bit_idx,
    input  logic             rise_p,
    input  logic             mdio_i,
    output logic [31:0]      data_q,
    output logic             mdio_o,
    output logic             mdio_oe
);
    logic [31:0] sreg_q;
    logic [15:0] rx_q;
    logic        is_read;
    logic [CNT_W:0] nxt_pos;

    assign is_read = (data_q[29:28] == OP_READ);
    assign nxt_pos = {1'b0, bit_idx} + (CNT_W+1)'(1);

    // command/data word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (cmd_wr) begin
            data_q <= wdata;
        end else if (finish && is_read) begin
            data_q[15:0] <= rx_q;
        end
    end

    // outgoing shift register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg_q <= '0;
        end else if (start) begin
            sreg_q <= wdata;
        end else if (shift_en) begin
            sreg_q <= {sreg_q[30:0], 1'b0};
        end
    end

    // line drivers, updated only at falling MDC edges or frame start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
        end else if (start) begin
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b1;
        end else if (load_first) begin
            mdio_o  <= sreg_q[31];
            mdio_oe <= 1'b1;
        end else if (shift_en) begin
            mdio_o  <= sreg_q[30];
            mdio_oe <= !(is_read && (nxt_pos >= (CNT_W+1)'(TA_POS)));
        end else if (finish) begin
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
        end
    end

    // read capture on rising MDC
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else if (rise_p && in_data && is_read) begin
            rx_q <= {rx_q[14:0], mdio_i};
        end
    end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_mgmt_pkg::*;
#(
    parameter int CLK_HZ     = 50_000_000,
    parameter int MDC_MAX_HZ = 2_500_000,
    parameter int SPD_W      = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        mii_done,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    localparam int MIN_HALF = (CLK_HZ + 2*MDC_MAX_HZ - 1) / (2*MDC_MAX_HZ);
    localparam logic [SPD_W-1:0] MIN_HALF_V = SPD_W'(MIN_HALF);

    logic [SPD_W-1:0] spd_q, half_q, half_eff;
    logic             busy, run, load_first, shift_en, finish, in_data;
    logic             rise_p, fall_p, cmd_wr, start;
    logic [CNT_W-1:0] bit_idx;

    assign cmd_wr   = wr_en && (wr_addr == ADDR_CMD) && !busy;
    assign start    = cmd_wr && (spd_q != '0);
    assign half_eff = (spd_q < MIN_HALF_V) ? MIN_HALF_V : spd_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spd_q  <= '0;
            half_q <= MIN_HALF_V;
        end else begin
            if (wr_en && (wr_addr == ADDR_SPEED)) spd_q <= wr_data[SPD_W-1:0];
            if (start) half_q <= half_eff;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mii_done <= 1'b0;
        end else if (finish) begin
            mii_done <= 1'b1;
        end else if (wr_en && (wr_addr == ADDR_EVENT) && wr_data[0]) begin
            mii_done <= 1'b0;
        end
    end

    mdio_clk_gen #(.SPD_W(SPD_W)) u_clk (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .half   (half_q),
        .mdc    (mdc),
        .rise_p (rise_p),
        .fall_p (fall_p)
    );

    mdio_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .fall_p     (fall_p),
        .busy       (busy),
        .run        (run),
        .load_first (load_first),
        .shift_en   (shift_en),
        .finish     (finish),
        .in_data    (in_data),
        .bit_idx    (bit_idx)
    );

    mdio_frame_path u_path (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_wr     (cmd_wr),
        .wdata      (wr_data),
        .start      (start),
        .load_first (load_first),
        .shift_en   (shift_en),
        .finish     (finish),
        .in_data    (in_data),
        .bit_idx    (bit_idx),
        .rise_p     (rise_p),
        .mdio_i     (mdio_i),
        .data_q     (rd_data),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe)
    );
endmodule

// File: rtl/mdio_mgmt_master_chk.sv
module mdio_mgmt_master_chk #(
    parameter int SPD_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic [31:0]      wr_data,
    input logic [31:0]      rd_data,
    input logic             mii_done,
    input logic             mdc,
    input logic             mdio_o,
    input logic             mdio_oe,
    input logic             busy,
    input logic [SPD_W-1:0] spd_q
);
    // R1: link quiet outside a frame
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

    // R11: line held while MDC is high
    a_r11_hold_while_high: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    // R8: zero speed never starts a frame
    a_r8_zero_speed_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && spd_q == '0) |=> !busy);

    // R9: event stays until a write of one
    a_r9_event_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (mii_done && !(wr_en && wr_addr == 2'd2 && wr_data[0])) |=> mii_done);

    // R10: command half of the word frozen while a frame runs
    a_r10_word_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(rd_data[31:16]));
endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk #(.SPD_W(SPD_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .mii_done (mii_done),
    .mdc      (mdc),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .busy     (busy),
    .spd_q    (spd_q)
);

// File: tb/mdio_mgmt_master_tb.sv
module mdio_mgmt_master_tb;
    localparam int HMIN = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        mii_done, mdc, mdio_o, mdio_oe;
    logic        mdio_in = 1'b1;

    int n_chk = 0;
    int n_fail = 0;
    logic [63:0] cap_bits = '0;
    logic [63:0] cap_oe = '0;
    int   cap_n = 0;
    time  t_rise = 0;
    time  hi_ns = 0;
    logic        phy_en = 1'b0;
    logic [15:0] phy_val = '0;

    always #10 clk = ~clk;

    mdio_mgmt_master u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_data(rd_data), .mii_done(mii_done),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_in)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!mii_done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic frame(input logic [31:0] cmd);
        cap_n = 0;
        wr(2'd0, cmd);
        wait_done();
    endtask

    // capture the line at rising MDC
    initial forever begin
        @(posedge mdc);
        #1;
        cap_bits = {cap_bits[62:0], mdio_o};
        cap_oe   = {cap_oe[62:0], mdio_oe};
        cap_n++;
        t_rise = $time;
    end
    initial forever begin
        @(negedge mdc);
        #1;
        hi_ns = $time - t_rise;
    end

    // PHY model: drives read data after the master releases the line
    initial forever begin
        @(negedge mdio_oe);
        if (phy_en) begin
            #1;
            @(negedge mdc);
            @(negedge mdc);
            for (int i = 15; i >= 0; i--) begin
                #1 mdio_in = phy_val[i];
                @(negedge mdc);
            end
            #1 mdio_in = 1'b1;
        end
    end

    initial begin
        #3_000_000;
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual %0d expected 0", 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] c1, c2, rc;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(mdc == 0 && mdio_oe == 0, "R1", "line at reset", {mdc, mdio_oe}, 0);
        check(mii_done == 0, "R1", "event at reset", mii_done, 0);
        check(rd_data == 0, "R1", "word at reset", rd_data, 0);

        // R8 zero speed: word written, nothing starts
        cap_n = 0;
        wr(2'd0, 32'h5002_1234);
        repeat (400) @(negedge clk);
        check(cap_n == 0, "R8", "mdc edges at speed 0", cap_n, 0);
        check(mii_done == 0, "R8", "event at speed 0", mii_done, 0);
        check(rd_data == 32'h5002_1234, "R8", "word at speed 0", rd_data, 32'h5002_1234);
        wr(2'd1, 32'd1);
        repeat (400) @(negedge clk);
        check(cap_n == 0 && mii_done == 0, "R8", "no late start", cap_n, 0);

        // write frame with speed 1 (clamped) and a mid-frame command
        c1 = 32'h5002_0000 | (32'd5 << 23) | (32'd9 << 18) | 32'hA5C3;
        c2 = 32'h6002_0000 | (32'd31 << 23);
        cap_n = 0;
        wr(2'd0, c1);
        repeat (300) @(negedge clk);
        wr(2'd0, c2);
        wait_done();
        check(hi_ns == HMIN*20, "R7", "clamped high time ns", hi_ns, HMIN*20);
        check(cap_n == 64, "R3", "frame length", cap_n, 64);
        check(cap_bits[63:32] == 32'hFFFF_FFFF && cap_oe[63:32] == 32'hFFFF_FFFF,
              "R2", "preamble", cap_bits[63:32], 32'hFFFF_FFFF);
        check(cap_bits[31:0] == c1, "R3", "write bits", cap_bits[31:0], c1);
        check(cap_oe[31:0] == 32'hFFFF_FFFF, "R4", "write oe", cap_oe[31:0], 32'hFFFF_FFFF);
        check(rd_data == c1, "R10", "busy write ignored", rd_data, c1);
        check(rd_data == c1, "R12", "word after write", rd_data, c1);
        check(mii_done == 1, "R9", "event set", mii_done, 1);
        check(mdc == 0 && mdio_oe == 0, "R1", "quiet after frame", {mdc, mdio_oe}, 0);

        // R9 W1C
        wr(2'd2, 32'd0);
        check(mii_done == 1, "R9", "write 0 keeps event", mii_done, 1);
        wr(2'd2, 32'd1);
        check(mii_done == 0, "R9", "write 1 clears", mii_done, 0);

        // R7 speed sweep around the floor
        foreach (c1[k]) begin
            if (k >= 5) continue;
            begin
                int s;
                int h;
                s = (k == 0) ? 9 : (k == 1) ? 10 : (k == 2) ? 11 : (k == 3) ? 13 : 2;
                h = (s < HMIN) ? HMIN : s;
                wr(2'd1, s);
                frame(32'h5002_0000 | (32'(k) << 18) | 32'(s));
                check(hi_ns == h*20, "R7", "high time ns", hi_ns, h*20);
                check(cap_n == 64, "R3", "frame length sweep", cap_n, 64);
                wr(2'd2, 32'd1);
            end
        end

        // R4/R5 read sweep with PHY driving
        wr(2'd1, 32'd10);
        phy_en = 1'b1;
        for (int k = 0; k < 6; k++) begin
            logic [15:0] v;
            v  = 16'h8001 ^ (16'h1357 * 16'(k + 1)) ^ (16'h1 << k);
            phy_val = v;
            rc = 32'h6002_0000 | (32'(k * 5) << 23) | (32'(31 - k) << 18) | 32'(k);
            frame(rc);
            check(cap_oe == 64'hFFFF_FFFF_FFFC_0000, "R4", "read oe pattern",
                  cap_oe, 64'hFFFF_FFFF_FFFC_0000);
            check(cap_bits[31:18] == rc[31:18], "R4", "read header bits",
                  cap_bits[31:18], rc[31:18]);
            check(rd_data == {rc[31:16], v}, "R5", "read data",
                  rd_data, {rc[31:16], v});
            wr(2'd2, 32'd1);
        end

        // R6 no PHY
        phy_en = 1'b0;
        rc = 32'h6002_0000 | (32'd3 << 23) | (32'd2 << 18);
        frame(rc);
        check(rd_data == {rc[31:16], 16'hFFFF}, "R6", "no PHY read",
              rd_data, {rc[31:16], 16'hFFFF});
        check(cap_bits[31:0] != 0 && mii_done, "R11", "frame completed cleanly",
              mii_done, 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule